// File: doc/BRIEF.md
# Pseudo-Random Bit Source with Density Shaping and Error Injection

This block is a bit-serial test pattern source. It emits one bit per clock from a maximal-length linear feedback shift register whose order is chosen from seven values. The bit stream then passes through a density shaper. The shaper can AND the current bit with one or two delayed copies of itself to thin out the ones. It can also invert that product, or replace the stream with a constant. A one-cycle marker shows where each pattern period starts.

An error injector can flip output bits deliberately. It has three sources, combined by OR: a decade-rate counter that flips one bit in every 10^n bits, a one-shot command that flips one bit per request, and an external strobe that flips every bit it covers. The injector is built from two small state machines. The rate machine has the states RT_IDLE and RT_RUN. It moves RT_IDLE→RT_RUN when a rate is enabled. It moves RT_RUN→RT_IDLE when the rate is switched off or changed. The one-shot machine has the states SG_READY and SG_SPENT. It moves SG_READY→SG_SPENT on a request, which fires the flip. It moves SG_SPENT→SG_READY once the request is released.

All configuration inputs are sampled on every clock. The data and marker outputs are registered, so a bit computed from the register state in one cycle appears on the pins after the next rising edge.

Top module: `prbs_mark_src`

## Requirements
- R1: The order code `order_sel_i` selects the feedback polynomial: 0→x^7+x^6+1, 1→x^9+x^5+1, 2→x^11+x^9+1, 3→x^15+x^14+1, 4→x^20+x^3+1, 5→x^23+x^18+1, 6→x^31+x^28+1, 7→same as 0. For order n, the raw bit is register bit n-1. The next state is (state<<1 | (bit[n-1] xor bit[k-1])) masked to n bits. The result of each cycle reaches `data_o` one clock later. When no flip is requested, `data_o` equals the shaped bit.
- R2: With a fixed order n and ratio code 0, the stream repeats every 2^n−1 bits and holds 2^(n-1) ones per period. `sync_o` is high for exactly one cycle per period, on the bit produced from the all-ones seed state, which is also the first bit after reset.
- R3: `ratio_sel_i` 0 gives the raw bit (density 1/2). Code 1 gives bit AND bit(t−d) (1/4). Code 2 gives bit AND bit(t−d) AND bit(t−2d) (1/8). The delay d is 1 when `shift_sel_i`=0 and 3 when `shift_sel_i`=1. Delayed copies read as 0 until enough bits have been produced after reset.
- R4: Ratio code 4 is the inverse of code 1 (3/4). Ratio code 5 is the inverse of code 2 (7/8).
- R5: Ratio code 3 drives a constant 0 and code 6 a constant 1. Code 7 behaves as code 0.
- R6: The register never holds all zeros. If a next state masked to the current order is zero, the all-ones seed of that order is loaded instead. On an order change the low n bits are kept.
- R7: `rate_sel_i` code e in 0..6 flips one output bit in every 10^(e+3) bits. After the rate is enabled, one idle cycle passes. The first flip then lands on the 10^(e+3)-th following bit.
- R8: `rate_sel_i`=7 disables rate injection. Changing the code while the counter runs gives two flip-free cycles. Counting then restarts from zero.
- R9: A rising request on `single_req_i` flips exactly one bit, the one in the cycle where the request is first seen. Holding the request longer causes no further flips. A new request is accepted after one low cycle.
- R10: Every cycle with `ext_err_i` high flips that cycle's bit. Coincident error sources combine by OR and never cancel.
- R11: While `rst` is high, `data_o` and `sync_o` are 0. The register takes the all-ones seed of the selected order, the delay history clears, and both injector machines return to their idle states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| order_sel_i | input | 3 | Polynomial order code |
| ratio_sel_i | input | 3 | Mark density code |
| shift_sel_i | input | 1 | Delay of the AND taps: 0 = 1 bit, 1 = 3 bits |
| rate_sel_i | input | 3 | Decade error rate code, 7 = off |
| single_req_i | input | 1 | One-shot error request |
| ext_err_i | input | 1 | External error strobe |
| data_o | output | 1 | Serial pattern output |
| sync_o | output | 1 | Pattern start marker |

## Verification
The bench runs full periods for orders 7 to 15 and counts the ones in them. A wrong tap or a register that can lock up would break the 2^n−1 spacing of the marker or the 2^(n-1) ones count. For order 7 it sweeps every density code with both delay settings and counts ones over the second period, which has to land on 64, 32, 16, 95, 111, 0 or 127. A delay line tapped at the wrong depth, or an inversion put on the wrong code, shows up directly in that count. The decade counter is checked at 10^3 and 10^4, across a mid-count rate change and after switching off. An off-by-one limit would put the flips one bit early or late, and a counter that is not restarted would fire too soon after the change. Holding the one-shot request high would expose a request that fires repeatedly. Overlapping the strobe with the one-shot would expose sources that XOR and cancel.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int MAX_ORDER = 31;
    localparam int IDX_W     = 5;
    localparam int CNT_W     = 30;
    localparam logic [2:0] RATE_OFF = 3'd7;

    typedef enum logic [2:0] {
        MR_HALF    = 3'd0,
        MR_QUARTER = 3'd1,
        MR_EIGHTH  = 3'd2,
        MR_ZERO    = 3'd3,
        MR_3Q      = 3'd4,
        MR_7E      = 3'd5,
        MR_ONE     = 3'd6,
        MR_RSV     = 3'd7
    } ratio_e;

    typedef enum logic {
        RT_IDLE = 1'b0,
        RT_RUN  = 1'b1
    } rate_st_e;

    typedef enum logic {
        SG_READY = 1'b0,
        SG_SPENT = 1'b1
    } one_st_e;

    // index of the output (top) bit for each order code
    function automatic logic [IDX_W-1:0] order_msb(input logic [2:0] code);
        logic [IDX_W-1:0] r;
        unique case (code)
            3'd0:    r = 5'd6;
            3'd1:    r = 5'd8;
            3'd2:    r = 5'd10;
            3'd3:    r = 5'd14;
            3'd4:    r = 5'd19;
            3'd5:    r = 5'd22;
            3'd6:    r = 5'd30;
            default: r = 5'd6;
        endcase
        return r;
    endfunction

    // index of the inner feedback tap for each order code
    function automatic logic [IDX_W-1:0] order_tap(input logic [2:0] code);
        logic [IDX_W-1:0] r;
        unique case (code)
            3'd0:    r = 5'd5;
            3'd1:    r = 5'd4;
            3'd2:    r = 5'd8;
            3'd3:    r = 5'd13;
            3'd4:    r = 5'd2;
            3'd5:    r = 5'd17;
            3'd6:    r = 5'd27;
            default: r = 5'd5;
        endcase
        return r;
    endfunction

    // 10^(e+3), computed rather than tabulated
    function automatic logic [CNT_W-1:0] decade_limit(input logic [2:0] e);
        logic [CNT_W-1:0] r;
        r = CNT_W'(1000);
        for (int i = 0; i < 6; i++) begin
            if (i < int'(e)) r = r * CNT_W'(10);
        end
        return r;
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_pkg::*;
#(
    parameter int W = MAX_ORDER
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   order_sel_i,
    output logic         bit_o,
    output logic         at_seed_o,
    output logic [W-1:0] state_o
);

    logic [W-1:0]     state_q;
    logic [W-1:0]     state_d;
    logic [W-1:0]     mask;
    logic [W:0]       one_hot;
    logic [IDX_W-1:0] msb_i;
    logic [IDX_W-1:0] tap_i;
    logic             fb;

    always_comb begin
        msb_i   = order_msb(order_sel_i);
        tap_i   = order_tap(order_sel_i);
        one_hot = (W+1)'(1) << (msb_i + 5'd1);
        mask    = W'(one_hot - (W+1)'(1));
        fb      = state_q[msb_i] ^ state_q[tap_i];
        state_d = ((state_q << 1) | W'(fb)) & mask;
        if (state_d == '0) begin
            state_d = mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= mask;
        end else begin
            state_q <= state_d;
        end
    end

    assign bit_o     = state_q[msb_i];
    assign at_seed_o = (state_q == mask);
    assign state_o   = state_q;

endmodule

// File: rtl/prbs_mark_shaper.sv
module prbs_mark_shaper
    import prbs_pkg::*;
#(
    parameter int MAX_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_i,
    input  logic [2:0] ratio_sel_i,
    input  logic       shift_sel_i,
    output logic       mark_o
);

    localparam int HIST = 2 * MAX_SHIFT;

    logic [HIST-1:0] hist_q;
    logic            tap1;
    logic            tap2;
    logic            and2;
    logic            and3;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST-2:0], bit_i};
        end
    end

    assign tap1 = shift_sel_i ? hist_q[MAX_SHIFT-1] : hist_q[0];
    assign tap2 = shift_sel_i ? hist_q[HIST-1]      : hist_q[1];
    assign and2 = bit_i & tap1;
    assign and3 = and2 & tap2;

    always_comb begin
        unique case (ratio_e'(ratio_sel_i))
            MR_HALF:    mark_o = bit_i;
            MR_QUARTER: mark_o = and2;
            MR_EIGHTH:  mark_o = and3;
            MR_ZERO:    mark_o = 1'b0;
            MR_3Q:      mark_o = ~and2;
            MR_7E:      mark_o = ~and3;
            MR_ONE:     mark_o = 1'b1;
            MR_RSV:     mark_o = bit_i;
            default:    mark_o = bit_i;
        endcase
    end

endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel_i,
    input  logic       single_req_i,
    input  logic       ext_err_i,
    output logic       flip_o,
    output logic       single_hit_o
);

    rate_st_e         rt_q, rt_d;
    one_st_e          sg_q, sg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;
    logic [2:0]       sel_q;
    logic             rate_on;
    logic             sel_moved;
    logic             rate_hit;
    logic             single_hit;

    assign limit     = decade_limit(rate_sel_i);
    assign rate_on   = (rate_sel_i != RATE_OFF);
    assign sel_moved = (rate_sel_i != sel_q);

    // state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rt_q  <= RT_IDLE;
            sg_q  <= SG_READY;
            cnt_q <= '0;
            sel_q <= RATE_OFF;
        end else begin
            rt_q  <= rt_d;
            sg_q  <= sg_d;
            cnt_q <= cnt_d;
            sel_q <= rate_sel_i;
        end
    end

    // decade rate machine
    always_comb begin
        rt_d     = rt_q;
        cnt_d    = cnt_q;
        rate_hit = 1'b0;
        unique case (rt_q)
            RT_IDLE: begin
                cnt_d = '0;
                if (rate_on) rt_d = RT_RUN;
            end
            RT_RUN: begin
                if (!rate_on || sel_moved) begin
                    rt_d  = RT_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == limit - CNT_W'(1)) begin
                    rate_hit = 1'b1;
                    cnt_d    = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: rt_d = RT_IDLE;
        endcase
    end

    // one-shot machine
    always_comb begin
        sg_d       = sg_q;
        single_hit = 1'b0;
        unique case (sg_q)
            SG_READY: begin
                if (single_req_i) begin
                    single_hit = 1'b1;
                    sg_d       = SG_SPENT;
                end
            end
            SG_SPENT: begin
                if (!single_req_i) sg_d = SG_READY;
            end
            default: sg_d = SG_READY;
        endcase
    end

    assign flip_o       = rate_hit | single_hit | ext_err_i;
    assign single_hit_o = single_hit;

endmodule

// File: rtl/prbs_mark_src.sv
module prbs_mark_src
    import prbs_pkg::*;
#(
    parameter int ORDER_MAX = MAX_ORDER,
    parameter int SHIFT_MAX = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] order_sel_i,
    input  logic [2:0] ratio_sel_i,
    input  logic       shift_sel_i,
    input  logic [2:0] rate_sel_i,
    input  logic       single_req_i,
    input  logic       ext_err_i,
    output logic       data_o,
    output logic       sync_o
);

    logic                 lfsr_bit;
    logic                 at_seed;
    logic [ORDER_MAX-1:0] lfsr_state;
    logic                 mark_bit;
    logic                 flip;
    logic                 single_hit;

    prbs_lfsr #(.W(ORDER_MAX)) u_lfsr (
        .clk         (clk),
        .rst         (rst),
        .order_sel_i (order_sel_i),
        .bit_o       (lfsr_bit),
        .at_seed_o   (at_seed),
        .state_o     (lfsr_state)
    );

    prbs_mark_shaper #(.MAX_SHIFT(SHIFT_MAX)) u_shape (
        .clk         (clk),
        .rst         (rst),
        .bit_i       (lfsr_bit),
        .ratio_sel_i (ratio_sel_i),
        .shift_sel_i (shift_sel_i),
        .mark_o      (mark_bit)
    );

    prbs_err_inject u_inj (
        .clk          (clk),
        .rst          (rst),
        .rate_sel_i   (rate_sel_i),
        .single_req_i (single_req_i),
        .ext_err_i    (ext_err_i),
        .flip_o       (flip),
        .single_hit_o (single_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            data_o <= mark_bit ^ flip;
            sync_o <= at_seed;
        end
    end

endmodule

// File: rtl/prbs_mark_src_chk.sv
module prbs_mark_src_chk
    import prbs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 data_o,
    input logic                 sync_o,
    input logic                 ext_err_i,
    input logic                 single_req_i,
    input logic [2:0]           ratio_sel_i,
    input logic [MAX_ORDER-1:0] lfsr_state,
    input logic                 mark_bit,
    input logic                 flip,
    input logic                 single_hit
);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!data_o && !sync_o));

    // R6
    nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    // R2
    sync_single_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);

    // R1
    clean_path_chk: assert property (@(posedge clk) disable iff (rst)
        !flip |=> (data_o == $past(mark_bit)));

    // R10
    ext_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ext_err_i |=> (data_o != $past(mark_bit)));

    // R9
    single_once_chk: assert property (@(posedge clk) disable iff (rst)
        single_hit |=> !single_hit);

    // R9
    single_cause_chk: assert property (@(posedge clk) disable iff (rst)
        single_hit |-> single_req_i);

    // R5
    const_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel_i == 3'd3 && !flip) |=> !data_o);

    // R5
    const_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel_i == 3'd6 && !flip) |=> data_o);

endmodule

bind prbs_mark_src prbs_mark_src_chk u_chk (.*);

// File: tb/prbs_mark_src_tb.sv
`timescale 1ns/1ps
module prbs_mark_src_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] order_sel = 3'd0;
    logic [2:0] ratio_sel = 3'd0;
    logic       shift_sel = 1'b0;
    logic [2:0] rate_sel  = 3'd7;
    logic       single_req = 1'b0;
    logic       ext_err   = 1'b0;
    logic       data_o;
    logic       sync_o;

    int checks = 0;
    int errors = 0;
    logic [30:0] ms;
    logic [5:0]  mh;

    always #2 clk = ~clk;

    prbs_mark_src u_dut (
        .clk          (clk),
        .rst          (rst),
        .order_sel_i  (order_sel),
        .ratio_sel_i  (ratio_sel),
        .shift_sel_i  (shift_sel),
        .rate_sel_i   (rate_sel),
        .single_req_i (single_req),
        .ext_err_i    (ext_err),
        .data_o       (data_o),
        .sync_o       (sync_o)
    );

    function automatic int olen(input logic [2:0] c);
        case (c)
            3'd1: return 9;
            3'd2: return 11;
            3'd3: return 15;
            3'd4: return 20;
            3'd5: return 23;
            3'd6: return 31;
            default: return 7;
        endcase
    endfunction

    function automatic int otap(input logic [2:0] c);
        case (c)
            3'd1: return 5;
            3'd2: return 9;
            3'd3: return 14;
            3'd4: return 3;
            3'd5: return 18;
            3'd6: return 28;
            default: return 6;
        endcase
    endfunction

    function automatic logic [30:0] omask(input logic [2:0] c);
        longint m;
        m = (longint'(1) << olen(c)) - 1;
        return m[30:0];
    endfunction

    function automatic logic shape(input logic b);
        logic d1, d2;
        d1 = shift_sel ? mh[2] : mh[0];
        d2 = shift_sel ? mh[5] : mh[1];
        case (ratio_sel)
            3'd1: return b & d1;
            3'd2: return b & d1 & d2;
            3'd3: return 1'b0;
            3'd4: return ~(b & d1);
            3'd5: return ~(b & d1 & d2);
            3'd6: return 1'b1;
            default: return b;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one bit: predict, advance the model, compare after the edge
    task automatic step(input logic fl, input string tag);
        int n, k;
        logic [30:0] mk, nx;
        logic b, ed, es, fbk;
        n  = olen(order_sel);
        k  = otap(order_sel);
        mk = omask(order_sel);
        b  = ms[n-1];
        ed = shape(b) ^ fl;
        es = (ms == mk);
        @(posedge clk);
        fbk = ms[n-1] ^ ms[k-1];
        nx  = ((ms << 1) | {30'b0, fbk}) & mk;
        if (nx == '0) nx = mk;
        ms = nx;
        mh = {mh[4:0], b};
        @(negedge clk);
        chk(tag, data_o, ed);
        chk("R2", sync_o, es);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", data_o, 1'b0);
        chk("R11", sync_o, 1'b0);
        rst = 1'b0;
        ms = omask(order_sel);
        mh = '0;
    endtask

    function automatic string rtag(input int r);
        if (r == 4 || r == 5) return "R4";
        if (r == 3 || r == 6 || r == 7) return "R5";
        return "R3";
    endfunction

    function automatic int ones_exp(input int r);
        case (r)
            1: return 32;
            2: return 16;
            3: return 0;
            4: return 95;
            5: return 111;
            6: return 127;
            default: return 64;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);

        // R1: stream of every order against the polynomial model
        for (int c = 0; c < 7; c++) begin
            order_sel = 3'(c);
            do_reset();
            repeat (300) step(1'b0, "R1");
        end

        // R2: period length and ones count, orders 7..15
        for (int c = 0; c < 4; c++) begin
            int per, ones;
            order_sel = 3'(c);
            do_reset();
            per  = (1 << olen(3'(c))) - 1;
            ones = 0;
            for (int i = 0; i <= per; i++) begin
                step(1'b0, "R1");
                chk("R2", sync_o, (i == 0 || i == per));
                if (i < per) ones += int'(data_o);
            end
            chk_int("R2", ones, (per + 1) / 2);
        end

        // R3 R4 R5: density sweep over order 7, both delays
        order_sel = 3'd0;
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 2; s++) begin
                int ones;
                ratio_sel = 3'(r);
                shift_sel = s[0];
                do_reset();
                ones = 0;
                for (int i = 0; i < 254; i++) begin
                    step(1'b0, rtag(r));
                    if (i >= 127) ones += int'(data_o);
                end
                chk_int(rtag(r), ones, ones_exp(r));
            end
        end

        // R6: order change mid-run keeps low bits, never locks
        ratio_sel = 3'd0;
        shift_sel = 1'b0;
        order_sel = 3'd6;
        do_reset();
        repeat (100) step(1'b0, "R6");
        order_sel = 3'd0;
        repeat (300) step(1'b0, "R6");
        order_sel = 3'd4;
        repeat (100) step(1'b0, "R6");

        // R7 R8: decade rates, change mid-count, switch off
        order_sel = 3'd1;
        do_reset();
        repeat (20) step(1'b0, "R8");
        rate_sel = 3'd0;
        step(1'b0, "R7");
        for (int j = 1; j <= 2100; j++) step((j % 1000) == 0, "R7");
        rate_sel = 3'd1;
        repeat (2) step(1'b0, "R8");
        for (int j = 1; j <= 10000; j++) step((j % 10000) == 0, "R7");
        rate_sel = 3'd7;
        repeat (1200) step(1'b0, "R8");

        // R9: one-shot requests
        single_req = 1'b1;
        step(1'b1, "R9");
        repeat (4) step(1'b0, "R9");
        single_req = 1'b0;
        step(1'b0, "R9");
        single_req = 1'b1;
        step(1'b1, "R9");
        single_req = 1'b0;
        repeat (3) step(1'b0, "R9");

        // R10: external strobe, and overlap with a one-shot
        ext_err = 1'b1;
        repeat (3) step(1'b1, "R10");
        ext_err = 1'b0;
        step(1'b0, "R10");
        ext_err = 1'b1;
        single_req = 1'b1;
        step(1'b1, "R10");
        ext_err = 1'b0;
        single_req = 1'b0;
        repeat (3) step(1'b0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule